// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM array out of power-up. After reset it waits for a start pulse. It then runs one fixed, timed sequence of commands and hands control to normal operation. First it lets power and clocks settle. It then issues a single NOP and a long idle gap, followed by one all-banks precharge. A configurable number of auto-refresh (CBR) commands come next, eight by default, and then a mode register set with a fixed address pattern. Last, it returns to the normal command code. Only after that does it raise a refresh-enable output for the periodic refresh logic, and a done flag with it.

The user gives every wait in microseconds, and the block turns it into clock cycles from the clock frequency parameter. A bench can therefore lower the frequency parameter to shorten the run. Command spacing is measured from one issue cycle to the next. Each command is presented for exactly one cycle, marked by a strobe. The control pins are plain level or pulse signals. There is no handshake, because the block is the sole source of commands during bring-up.

Top module: `sdram_init_seq`

## Requirements
- R1: The command output uses normal=000, NOP=001, precharge-all=010, mode-register-set=011 and auto-refresh=100. The codes 101, 110 and 111 never appear.
- R2: During reset and while idle, the outputs are: command NOP (001), strobe low, address zero, done low, refresh-enable low.
- R3: The start pulse is sampled at a clock edge. The NOP is issued W_STAB cycles later, where W_STAB = max(STAB_US*CLK_MHZ, 2).
- R4: The precharge-all is issued W_NOP cycles after the NOP, where W_NOP = max(NOP_US*CLK_MHZ, NOP_MIN_CLK), with NOP_MIN_CLK = 200.
- R5: The first auto-refresh is issued TRP_CLK cycles after the precharge-all. TRP_CLK is 2 or 3.
- R6: Exactly NUM_REF auto-refresh commands (default 8) are issued, TRC_CLK cycles apart. The mode register set follows TRC_CLK cycles after the last one.
- R7: The address output carries MODE_ADDR (default 0x1D0) only in the mode-register-set issue cycle and is zero otherwise. The normal code is issued TMRD_CLK cycles (at least 2) after the mode register set.
- R8: From the normal-code issue cycle onward, the command output stays 000. Refresh-enable rises W_NRM = max(NRM_US*CLK_MHZ, 2) cycles after that issue.
- R9: Done rises in the same cycle as refresh-enable. Both stay high until reset.
- R10: A start pulse has no effect while the sequence is running or after it has finished.
- R11: The strobe is high for exactly one cycle per issued command and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins the bring-up sequence |
| cmd_o | output | 3 | Command code (see R1) |
| cmd_stb_o | output | 1 | High in the cycle a command is issued |
| addr_o | output | ADDR_W | Address lines; mode pattern during mode register set |
| done_o | output | 1 | Sequence complete, held until reset |
| refresh_en_o | output | 1 | Enables the periodic refresh logic |

## Verification
The assertions check on every cycle that no reserved code appears. They also check that the address is nonzero only with a mode-register-set strobe, that the strobe never lasts two cycles, and that done and refresh-enable rise together, never fall, and coincide with the normal code. The refresh counter is checked never to pass its limit. Only the bench's scenarios can show the exact issue cycle of every command and that there are exactly eight refreshes. They also show that start pulses in the middle of the sequence and after completion are ignored, and that a reset in the middle of the sequence leads to a clean restart. The bench shows these by comparing every cycle against a schedule it computes itself.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [2:0] {
    CMD_NORMAL  = 3'b000,
    CMD_NOP     = 3'b001,
    CMD_PRECH   = 3'b010,
    CMD_MODESET = 3'b011,
    CMD_AUTOREF = 3'b100
  } cmd_e;

  // microseconds to clock cycles, never below a floor
  function automatic int unsigned us_to_clk(int unsigned us, int unsigned mhz,
                                            int unsigned floor_c);
    int unsigned v;
    v = us * mhz;
    return (v < floor_c) ? floor_c : v;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdinit_wait_timer.sv
module sdinit_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdinit_fsm.sv
module sdinit_fsm
  import sdinit_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int W_STAB  = 200,
  parameter int W_NOP   = 200,
  parameter int W_TRP   = 3,
  parameter int W_TRC   = 7,
  parameter int W_TMRD  = 2,
  parameter int W_NRM   = 2,
  parameter int NUM_REF = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             issue,
  output cmd_e             issue_cmd,
  output logic             normal_mode,
  output logic             done
);

  localparam int RC_W = $clog2(NUM_REF + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_STAB, S_NOP, S_NOPW, S_PRE, S_PREW, S_REF, S_REFW,
    S_MRS, S_MRSW, S_NRM, S_NRMW, S_DONE
  } st_e;

  st_e            st_q, st_d;
  logic [RC_W-1:0] ref_q;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      S_IDLE: if (start) begin
        st_d = S_STAB; tmr_load = 1'b1; tmr_val = CNT_W'(W_STAB - 1);
      end
      S_STAB: if (tmr_zero) st_d = S_NOP;
      S_NOP:  begin st_d = S_NOPW; tmr_load = 1'b1; tmr_val = CNT_W'(W_NOP - 2); end
      S_NOPW: if (tmr_zero) st_d = S_PRE;
      S_PRE:  begin st_d = S_PREW; tmr_load = 1'b1; tmr_val = CNT_W'(W_TRP - 2); end
      S_PREW: if (tmr_zero) st_d = S_REF;
      S_REF:  begin st_d = S_REFW; tmr_load = 1'b1; tmr_val = CNT_W'(W_TRC - 2); end
      S_REFW: if (tmr_zero) st_d = (ref_q == RC_W'(NUM_REF)) ? S_MRS : S_REF;
      S_MRS:  begin st_d = S_MRSW; tmr_load = 1'b1; tmr_val = CNT_W'(W_TMRD - 2); end
      S_MRSW: if (tmr_zero) st_d = S_NRM;
      S_NRM:  begin st_d = S_NRMW; tmr_load = 1'b1; tmr_val = CNT_W'(W_NRM - 2); end
      S_NRMW: if (tmr_zero) st_d = S_DONE;
      default: st_d = st_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      ref_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_REF) ref_q <= ref_q + 1'b1;
    end
  end

  always_comb begin
    issue     = 1'b1;
    issue_cmd = CMD_NOP;
    case (st_q)
      S_NOP:   issue_cmd = CMD_NOP;
      S_PRE:   issue_cmd = CMD_PRECH;
      S_REF:   issue_cmd = CMD_AUTOREF;
      S_MRS:   issue_cmd = CMD_MODESET;
      S_NRM:   issue_cmd = CMD_NORMAL;
      default: issue     = 1'b0;
    endcase
  end

  assign normal_mode = (st_q == S_NRM) || (st_q == S_NRMW) || (st_q == S_DONE);
  assign done        = (st_q == S_DONE);

  AST_REF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q <= RC_W'(NUM_REF)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R9

endmodule

// File: rtl/sdinit_cmd_enc.sv
module sdinit_cmd_enc
  import sdinit_pkg::*;
#(
  parameter int          ADDR_W    = 13,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 13'h1D0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  cmd_e              issue_cmd,
  input  logic              normal_mode,
  output logic [2:0]        cmd_o,
  output logic              stb_o,
  output logic [ADDR_W-1:0] addr_o
);

  always_comb begin
    if (issue)            cmd_o = issue_cmd;
    else if (normal_mode) cmd_o = CMD_NORMAL;
    else                  cmd_o = CMD_NOP;
  end

  assign stb_o  = issue;
  assign addr_o = (issue && issue_cmd == CMD_MODESET) ? MODE_ADDR : '0;

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o <= 3'b100); // R1
  AST_ADDR_ONLY_MRS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_o != '0) |-> (stb_o && cmd_o == 3'b011)); // R7
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> !stb_o); // R11

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter int          CLK_MHZ     = 100,
  parameter int          STAB_US     = 200,
  parameter int          NOP_US      = 200,
  parameter int          NOP_MIN_CLK = 200,
  parameter int          TRP_CLK     = 3,
  parameter int          TRC_CLK     = 7,
  parameter int          TMRD_CLK    = 2,
  parameter int          NRM_US      = 1,
  parameter int          NUM_REF     = 8,
  parameter int          ADDR_W      = 13,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 13'h1D0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [2:0]        cmd_o,
  output logic              cmd_stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              refresh_en_o
);

  localparam int W_STAB = int'(us_to_clk(STAB_US, CLK_MHZ, 2));
  localparam int W_NOP  = int'(us_to_clk(NOP_US, CLK_MHZ, NOP_MIN_CLK));
  localparam int W_NRM  = int'(us_to_clk(NRM_US, CLK_MHZ, 2));
  localparam int W_TRP  = (TRP_CLK < 2) ? 2 : TRP_CLK;
  localparam int W_TRC  = (TRC_CLK < 2) ? 2 : TRC_CLK;
  localparam int W_TMRD = (TMRD_CLK < 2) ? 2 : TMRD_CLK;
  localparam int W_MAX  = int'(max2(max2(W_STAB, W_NOP), max2(W_NRM, max2(W_TRC, W_TMRD))));
  localparam int CNT_W  = $clog2(W_MAX + 1);

  logic             tmr_load, tmr_zero, issue, normal_mode, done;
  logic [CNT_W-1:0] tmr_val;
  cmd_e             issue_cmd;

  sdinit_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sdinit_fsm #(
    .CNT_W(CNT_W), .W_STAB(W_STAB), .W_NOP(W_NOP), .W_TRP(W_TRP), .W_TRC(W_TRC),
    .W_TMRD(W_TMRD), .W_NRM(W_NRM), .NUM_REF(NUM_REF)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .issue(issue), .issue_cmd(issue_cmd),
    .normal_mode(normal_mode), .done(done)
  );

  sdinit_cmd_enc #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) u_enc (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_cmd(issue_cmd),
    .normal_mode(normal_mode), .cmd_o(cmd_o), .stb_o(cmd_stb_o), .addr_o(addr_o)
  );

  assign done_o       = done;
  assign refresh_en_o = done;

  AST_REF_AFTER_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_en_o |-> (cmd_o == 3'b000)); // R8
  AST_DONE_WITH_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_en_o) |-> $rose(done_o)); // R9

endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;

  localparam int MHZ = 1;
  localparam int S = 200, N = 200, P = 3, C = 7, NREF = 8, MR = 2, NR = 2;
  localparam int T_NOP = S, T_PRE = S + N, T_REF0 = S + N + P;
  localparam int T_MRS = T_REF0 + NREF * C, T_NRM = T_MRS + MR, T_DONE = T_NRM + NR;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] cmd;
  logic stb, done, ref_en;
  logic [12:0] addr;

  int n_tests = 0, n_fail = 0;
  int t = 0;
  bit running = 1'b0;
  int n_stb = 0, n_ref = 0;

  always #2.5 clk = ~clk;

  sdram_init_seq #(.CLK_MHZ(MHZ), .TRP_CLK(P), .TRC_CLK(C)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_o(cmd), .cmd_stb_o(stb),
    .addr_o(addr), .done_o(done), .refresh_en_o(ref_en)
  );

  // reference model: cycle counter since accepted start
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin running <= 1'b0; t <= 0; end
    else if (running) t <= t + 1;
    else if (start) begin running <= 1'b1; t <= 0; end
  end

  function automatic string tag_of(int tt);
    if (tt < T_NOP)  return "R3";
    if (tt < T_PRE)  return "R4";
    if (tt < T_REF0) return "R5";
    if (tt < T_MRS)  return "R6";
    if (tt < T_NRM)  return "R7";
    if (tt < T_DONE) return "R8";
    return "R9";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0d)", req, what, act, exp, t);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [2:0] e_cmd; logic e_stb, e_done; logic [12:0] e_addr; string rq;
    e_cmd = 3'b001; e_stb = 1'b0; e_done = 1'b0; e_addr = '0; rq = "R2";
    if (running) begin
      rq = tag_of(t);
      if (t >= T_NRM) e_cmd = 3'b000;
      if (t >= T_DONE) e_done = 1'b1;
      if (t == T_NOP) begin e_cmd = 3'b001; e_stb = 1'b1; end
      if (t == T_PRE) begin e_cmd = 3'b010; e_stb = 1'b1; end
      if (t >= T_REF0 && t < T_MRS && ((t - T_REF0) % C) == 0) begin
        e_cmd = 3'b100; e_stb = 1'b1;
      end
      if (t == T_MRS) begin e_cmd = 3'b011; e_stb = 1'b1; e_addr = 13'h1D0; end
      if (t == T_NRM) begin e_cmd = 3'b000; e_stb = 1'b1; end
    end
    chk(rq, {29'd0, cmd}, {29'd0, e_cmd}, "cmd");
    chk("R11", {31'd0, stb}, {31'd0, e_stb}, "strobe");
    chk("R7", {19'd0, addr}, {19'd0, e_addr}, "addr");
    chk("R9", {30'd0, done, ref_en}, {30'd0, e_done, e_done}, "done/refresh_en");
    if (cmd > 3'b100) chk("R1", {29'd0, cmd}, 32'd4, "reserved code");
    if (stb) n_stb++;
    if (stb && cmd == 3'b100) n_ref++;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_start();
    start = 1'b1; cyc(1); start = 1'b0;
  endtask

  initial begin
    cyc(5);
    chk("R2", {29'd0, cmd, done, ref_en}, {29'd0, 3'b001, 2'b00}, "reset state");
    rst_n = 1'b1; cyc(3);
    chk("R2", {30'd0, stb, done}, 32'd0, "idle state");
    n_stb = 0; n_ref = 0;
    pulse_start();
    cyc(100);
    pulse_start();                 // R10: ignored while running
    cyc(T_DONE + 20 - 101);
    chk("R6", n_ref, NREF, "refresh count");
    chk("R10", n_stb, NREF + 4, "total command strobes");
    pulse_start();                 // R10: ignored after completion
    cyc(30);
    chk("R10", {31'd0, done}, 32'd1, "done after late start");
    chk("R10", n_stb, NREF + 4, "no new commands after late start");
    // reset in the middle, then a clean second run
    n_stb = 0; n_ref = 0;
    pulse_start(); cyc(50);
    chk("R10", {31'd0, done}, 32'd1, "start after done still ignored");
    rst_n = 1'b0; cyc(2);
    chk("R2", {29'd0, cmd, done, ref_en}, {29'd0, 3'b001, 2'b00}, "reset clears done");
    rst_n = 1'b1; cyc(2);
    n_stb = 0; n_ref = 0;
    pulse_start(); cyc(250);
    rst_n = 1'b0; cyc(2);
    chk("R2", {30'd0, stb, done}, 32'd0, "mid-sequence reset");
    rst_n = 1'b1; cyc(2);
    n_stb = 0; n_ref = 0;
    pulse_start(); cyc(T_DONE + 10);
    chk("R6", n_ref, NREF, "refresh count second run");
    chk("R8", {29'd0, cmd}, 32'd0, "normal code held");
    chk("R9", {30'd0, done, ref_en}, 32'd3, "done and refresh_en set");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule